// File: doc/BRIEF.md
# Serial flash protocol mode controller

This block sits inside a serial flash slave. It keeps the volatile enhanced configuration byte and turns it into three controls. The first is the bus protocol in use: extended single-line, dual I/O or quad I/O. The second enables the hold/reset pin function. The third allows the accelerator (high programming) voltage to be used with quad program and erase operations. A command decoder upstream supplies a write strobe with the new byte when a register-write instruction completes. It also pulses an event when it has taken in a complete quad program or an erase. An analog comparator supplies a flag that is high while the accelerator voltage is raised.

Quad protocol wins over dual when both are requested. The protocol never changes while the device is selected. When quad protocol is active and the accelerator voltage is permitted, a quad program or erase followed by deselect drops the bus back to extended protocol. This lets status polling and suspend commands work while the third data line carries the high voltage. The bus stays extended until the accelerator flag falls, and then quad protocol resumes.

Top module: `flash_proto_mode`

## Requirements
- R1: While `rst_n` is low at a clock edge, the configuration byte is loaded with all ones except bit 4, which takes the value of `nv_hold_cfg`. After reset, `mode` is 2'b00, `acc_en` is 0 and `hold_en` equals `nv_hold_cfg`.
- R2: With configuration bit 7 at 0 and bit 6 at 1, `mode` becomes 2'b10 (quad).
- R3: With bit 7 at 1 and bit 6 at 0, `mode` becomes 2'b01 (dual).
- R4: With bits 7 and 6 both 0, `mode` becomes 2'b10 (quad takes priority over dual).
- R5: With bits 7 and 6 both 1, `mode` is 2'b00 (extended).
- R6: `mode` is loaded only at clock edges where `cs_n` is high. A configuration byte written while `cs_n` is low changes `mode` no earlier than the clock edge after `cs_n` goes high. With `cs_n` high, `mode` reflects a write two edges after the write strobe.
- R7: A write strobe loads `cfg_wdata` into the configuration byte at the clock edge. `hold_en` equals bit 4 of the stored byte from that edge on.
- R8: `acc_en` is the inverse of configuration bit 3 and updates at the clock edge of the write.
- R9: Let bit 7 be 0 and bit 3 be 0, and let `quad_mod_done` pulse. At the next edge where `cs_n` is high, a fallback flag is set. From the edge after that, `mode` is 2'b00 for as long as the flag stays set.
- R10: The fallback flag is cleared at the first clock edge where `vacc_high` is low after being high at the edge before. Quad mode then returns one edge later.
- R11: A `quad_mod_done` pulse has no effect on `mode` while configuration bit 3 is 1.
- R12: The fallback flag overrides only quad mode. With the flag set, a dual configuration still gives `mode` 2'b01, and a quad configuration gives 2'b00 until the flag clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| nv_hold_cfg | input | 1 | Non-volatile hold setting; 0 starts with hold/reset disabled |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte value |
| cs_n | input | 1 | Chip select, active low |
| quad_mod_done | input | 1 | Pulse: quad program or erase fully received |
| vacc_high | input | 1 | Accelerator voltage is at its raised level |
| mode | output | 2 | Protocol: 00 extended, 01 dual, 10 quad |
| hold_en | output | 1 | Hold/reset pin function enabled |
| acc_en | output | 1 | Accelerator voltage permitted for quad modify operations |

## Verification
The bench builds the block with its default parameters: an 8-bit configuration byte, quad and dual selects at bits 7 and 6, hold at bit 4 and accelerator at bit 3. Those values bring the fixed bit positions used in the table vectors within reach. They also give the exact reset byte, with only bit 4 taken from the non-volatile input. The directed tests reach a write held back by an active select and the full fallback round trip. They also cover a fallback masked by a dual configuration and an event that is ignored because the accelerator bit is 1.

// File: rtl/flash_proto_mode.sv
module flash_proto_mode #(
  parameter int CFG_W    = 8,
  parameter int QUAD_BIT = 7,
  parameter int DUAL_BIT = 6,
  parameter int HOLD_BIT = 4,
  parameter int ACC_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_hold_cfg,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cs_n,
  input  logic             quad_mod_done,
  input  logic             vacc_high,
  output logic [1:0]       mode,
  output logic             hold_en,
  output logic             acc_en
);

  localparam logic [1:0]       M_EXT     = 2'b00;
  localparam logic [1:0]       M_DUAL    = 2'b01;
  localparam logic [1:0]       M_QUAD    = 2'b10;
  localparam logic [CFG_W-1:0] CFG_ONES  = {CFG_W{1'b1}};
  localparam logic [CFG_W-1:0] HOLD_MASK = CFG_W'(1) << HOLD_BIT;

  logic [CFG_W-1:0] cfg;
  logic             armed;
  logic             fb;
  logic             vacc_q;
  logic [1:0]       mode_nx;

  wire quad_req  = ~cfg[QUAD_BIT];
  wire dual_req  = ~cfg[DUAL_BIT];
  wire vacc_fall = vacc_q & ~vacc_high;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg <= (CFG_ONES & ~HOLD_MASK) | ({CFG_W{nv_hold_cfg}} & HOLD_MASK);
    else if (cfg_we)
      cfg <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      fb     <= 1'b0;
      vacc_q <= 1'b0;
    end else begin
      vacc_q <= vacc_high;
      if (quad_mod_done && quad_req && !cfg[ACC_BIT])
        armed <= 1'b1;
      else if (cs_n)
        armed <= 1'b0;
      if (vacc_fall)
        fb <= 1'b0;
      else if (armed && cs_n)
        fb <= 1'b1;
    end
  end

  always_comb begin
    if (quad_req)      mode_nx = fb ? M_EXT : M_QUAD;
    else if (dual_req) mode_nx = M_DUAL;
    else               mode_nx = M_EXT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    mode <= M_EXT;
    else if (cs_n) mode <= mode_nx;
  end

  assign hold_en = cfg[HOLD_BIT];
  assign acc_en  = ~cfg[ACC_BIT];

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cfg_we) |=> (cfg == $past(cfg_wdata))); // R7
  AST_HOLD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cfg_we) |=> (hold_en == $past(cfg_wdata[HOLD_BIT]))); // R7
  AST_ACC_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cfg_we) |=> (acc_en == !$past(cfg_wdata[ACC_BIT]))); // R8
  AST_MODE_FROZEN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cs_n)) |-> $stable(mode)); // R6
  AST_FB_BLOCKS_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && fb) |=> (mode != M_QUAD)); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11); // R5

endmodule

// File: tb/tb_flash_proto_mode.sv
module tb_flash_proto_mode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_hold_cfg = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       cs_n = 1'b1;
  logic       quad_mod_done = 1'b0;
  logic       vacc_high = 1'b0;
  logic [1:0] mode;
  logic       hold_en;
  logic       acc_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_proto_mode dut (
    .clk(clk), .rst_n(rst_n), .nv_hold_cfg(nv_hold_cfg), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cs_n(cs_n), .quad_mod_done(quad_mod_done),
    .vacc_high(vacc_high), .mode(mode), .hold_en(hold_en), .acc_en(acc_en)
  );

  // {cfg byte, mode, hold_en, acc_en}: R2 R3 R4 R5 R7 R8
  localparam logic [11:0] VEC [0:8] = '{
    {8'hFF, 2'b00, 1'b1, 1'b0},
    {8'h7F, 2'b10, 1'b1, 1'b0},
    {8'hBF, 2'b01, 1'b1, 1'b0},
    {8'h3F, 2'b10, 1'b1, 1'b0},
    {8'hEF, 2'b00, 1'b0, 1'b0},
    {8'hF7, 2'b00, 1'b1, 1'b1},
    {8'h70, 2'b10, 1'b1, 1'b1},
    {8'h80, 2'b01, 1'b0, 1'b1},
    {8'hC8, 2'b00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [1:0] m, input logic h, input logic a);
    checks++;
    if (mode !== m || hold_en !== h || acc_en !== a) begin
      errors++;
      $display("FAIL %s: mode=%b hold=%b acc=%b expected mode=%b hold=%b acc=%b",
               req, mode, hold_en, acc_en, m, h, a);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [7:0] v);
    wr(v);
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire_event();
    @(negedge clk); quad_mod_done = 1'b1;
    @(negedge clk); quad_mod_done = 1'b0;
  endtask

  initial begin
    cycles(3);
    chk("R1 reset nv=0", 2'b00, 1'b0, 1'b0);
    nv_hold_cfg = 1'b1;
    cycles(2);
    chk("R1 reset nv=1", 2'b00, 1'b1, 1'b0);
    rst_n = 1'b1;
    cycles(2);
    chk("R1 after release", 2'b00, 1'b1, 1'b0);

    for (int i = 0; i < 9; i++) begin
      apply(VEC[i][11:4]);
      chk($sformatf("table vec %0d (R2 R3 R4 R5 R7 R8)", i),
          VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R6: write under active select
    apply(8'hFF);
    cs_n = 1'b0;
    apply(8'h7F);
    cycles(3);
    chk("R6 held while selected", 2'b00, 1'b1, 1'b0);
    cs_n = 1'b1;
    cycles(1);
    chk("R6 applied on deselect", 2'b10, 1'b1, 1'b0);

    // R9/R10: fallback round trip
    apply(8'h77);
    chk("R2 quad with acc", 2'b10, 1'b1, 1'b1);
    cs_n = 1'b0; vacc_high = 1'b1;
    fire_event();
    cycles(2);
    chk("R9 no change while selected", 2'b10, 1'b1, 1'b1);
    cs_n = 1'b1;
    cycles(2);
    chk("R9 fallback to extended", 2'b00, 1'b1, 1'b1);
    cycles(5);
    chk("R10 stays extended while vacc high", 2'b00, 1'b1, 1'b1);
    vacc_high = 1'b0;
    cycles(2);
    chk("R10 quad after vacc falls", 2'b10, 1'b1, 1'b1);

    // R12: flag masked by dual config
    cs_n = 1'b0; vacc_high = 1'b1;
    fire_event();
    cs_n = 1'b1;
    cycles(2);
    chk("R12 fallback set", 2'b00, 1'b1, 1'b1);
    apply(8'hB7);
    chk("R12 dual unaffected by flag", 2'b01, 1'b1, 1'b1);
    apply(8'h77);
    chk("R12 quad overridden by flag", 2'b00, 1'b1, 1'b1);
    vacc_high = 1'b0;
    cycles(2);
    chk("R12 quad after clear", 2'b10, 1'b1, 1'b1);

    // R11: event ignored with accelerator bit at 1
    apply(8'h7F);
    cs_n = 1'b0; vacc_high = 1'b1;
    fire_event();
    cs_n = 1'b1;
    cycles(4);
    chk("R11 event ignored", 2'b10, 1'b1, 1'b0);
    vacc_high = 1'b0;
    cycles(2);
    chk("R11 still quad", 2'b10, 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule